// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block produces the frame timing for a full-speed USB host controller. It counts bit times of the 12 MHz bus through a one-cycle enable, `bit_en`. A frame lasts 11936 plus an 8-bit adjust value of bit times. At each frame boundary the block steps an 11-bit frame number. In the same cycle it raises a start-of-frame strobe and a request to fetch the next frame list entry.

The frame list is a page-aligned table of 1024 word entries in memory. The block keeps only the page bits of the base address. It forms each fetch address from those page bits and the low ten bits of the frame number. When the memory side returns an entry with `entry_valid`, the block splits the word into a 16-byte-aligned pointer and an empty-entry flag.

Counting happens only while `run` is high. Software may load the frame number while the controller is halted. It may write the adjust value at any time. A new adjust value applies from the next frame boundary.

Top module: `sof_frame_timer`

## Requirements
- R1: After reset the frame number is 0, the adjust register reads 64, the base register reads 0, and both strobes are low.
- R2: While `run` is high and `bit_en` is high every cycle, `sof_pulse` and `fetch_req` are high together for exactly one cycle every 11936 + adjust cycles, and the frame number shown in that cycle is one greater than in the cycle before.
- R3: A write to the adjust register shows on `adj_q` in the next cycle. The frame in progress keeps its old length, and the next frame uses the new length.
- R4: While `run` is low the bit counter and the frame number hold and no strobe is issued. After `run` rises again, the current frame completes with only its remaining bit times.
- R5: A frame number write (`frnum_we`) takes effect only while `run` is low. While `run` is high the write is ignored.
- R6: The frame number wraps from 2047 to 0.
- R7: A write to the base register keeps bits 31:12. `base_q` bits 11:0 read as zero.
- R8: `fetch_addr` equals {base bits 31:12, frame number bits 9:0, 2'b00}, so frame numbers 1024 and 0 select the same entry.
- R9: On `entry_valid` the next cycle shows `entry_ptr` = {entry bits 31:4, 4'b0} and `entry_term` = entry bit 0. Without `entry_valid` both outputs hold their values.
- R10: The bit counter advances only in cycles where `bit_en` is high. With `bit_en` high every other cycle, a 12000-bit frame spans 23999 clock cycles from the boundary that starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle enable per 12 MHz bit time |
| run | input | 1 | Controller running; counting is frozen when low |
| frnum_we | input | 1 | Frame number write strobe (accepted only while halted) |
| frnum_wdata | input | 11 | Frame number write data |
| adj_we | input | 1 | Adjust register write strobe |
| adj_wdata | input | 8 | Adjust register write data |
| base_we | input | 1 | Frame list base write strobe |
| base_wdata | input | 32 | Frame list base write data |
| entry_valid | input | 1 | Fetched frame list entry is present |
| entry_data | input | 32 | Fetched frame list entry |
| frnum | output | 11 | Current frame number |
| adj_q | output | 8 | Adjust register value |
| base_q | output | 32 | Frame list base, low 12 bits zero |
| fetch_addr | output | 32 | Address of the current frame list entry |
| sof_pulse | output | 1 | Start-of-frame strobe |
| fetch_req | output | 1 | Frame list fetch request strobe |
| entry_ptr | output | 32 | Decoded entry pointer |
| entry_term | output | 1 | Decoded empty-entry flag |

## Verification
The hardest cases to reach from the ports are the frame number wraps at 1023→1024 and 2047→0. Reaching them by counting would take about two thousand frames. The stimulus instead halts the controller at a frame boundary, loads 1023 or 2047, and restarts. The fetch address must then fall back to the base and the frame number must wrap. A halt in the middle of a frame and a run of alternating `bit_en` cycles show that the counter counts only real bit times. Adjust writes in the middle of a frame show that the new length is deferred to the next frame.

// File: rtl/sof_frame_timer.sv
module sof_frame_timer #(
  parameter int FNUM_W   = 11,
  parameter int ADJ_W    = 8,
  parameter int BASE_LEN = 11936,
  parameter int ADJ_RST  = 64,
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              run,
  input  logic              frnum_we,
  input  logic [FNUM_W-1:0] frnum_wdata,
  input  logic              adj_we,
  input  logic [ADJ_W-1:0]  adj_wdata,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              entry_valid,
  input  logic [ADDR_W-1:0] entry_data,
  output logic [FNUM_W-1:0] frnum,
  output logic [ADJ_W-1:0]  adj_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              sof_pulse,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] entry_ptr,
  output logic              entry_term
);
  localparam int IDX_W = PAGE_W - 2;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(BASE_LEN + (1 << ADJ_W));
  localparam logic [CNT_W-1:0] LEN_M1 = CNT_W'(BASE_LEN - 1);

  logic [CNT_W-1:0] cnt;
  logic [ADJ_W-1:0] adj_cur;
  logic [PG_W-1:0]  base_pg;
  logic             strobe;
  logic             tick, frame_end;

  assign tick      = run && bit_en;
  assign frame_end = tick && (cnt == LEN_M1 + CNT_W'(adj_cur));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      frnum   <= '0;
      adj_cur <= ADJ_W'(ADJ_RST);
      strobe  <= 1'b0;
    end else begin
      strobe <= frame_end;
      if (frame_end) begin
        cnt     <= '0;
        frnum   <= frnum + 1'b1;
        adj_cur <= adj_q;
      end else begin
        if (tick) cnt <= cnt + 1'b1;
        if (frnum_we && !run) frnum <= frnum_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adj_q   <= ADJ_W'(ADJ_RST);
      base_pg <= '0;
    end else begin
      if (adj_we)  adj_q   <= adj_wdata;
      if (base_we) base_pg <= base_wdata[ADDR_W-1:PAGE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_ptr  <= '0;
      entry_term <= 1'b0;
    end else if (entry_valid) begin
      entry_ptr  <= {entry_data[ADDR_W-1:4], 4'b0000};
      entry_term <= entry_data[0];
    end
  end

  assign base_q     = {base_pg, {PAGE_W{1'b0}}};
  assign fetch_addr = {base_pg, frnum[IDX_W-1:0], 2'b00};
  assign sof_pulse  = strobe;
  assign fetch_req  = strobe;

  wire unused_bits = ^{base_wdata[PAGE_W-1:0], entry_data[3:1]};
endmodule

module sof_frame_timer_chk #(
  parameter int FNUM_W = 11,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              frnum_we,
  input logic              sof_pulse,
  input logic              fetch_req,
  input logic [FNUM_W-1:0] frnum,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] base_q,
  input logic              entry_valid,
  input logic [ADDR_W-1:0] entry_data,
  input logic              entry_term
);
  AST_SOF_STEPS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (fetch_req && frnum == FNUM_W'($past(frnum) + 1'b1))); // R2
  AST_SOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !frnum_we) |=> ($stable(frnum) && !sof_pulse)); // R4
  AST_RUN_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (frnum == $past(frnum) || frnum == FNUM_W'($past(frnum) + 1'b1))); // R5
  AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_addr[31:12] == base_q[31:12] && fetch_addr[11:2] == frnum[9:0])); // R8
  AST_ENTRY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |=> (entry_term == $past(entry_data[0]))); // R9
endmodule

bind sof_frame_timer sof_frame_timer_chk #(.FNUM_W(FNUM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .frnum_we(frnum_we),
  .sof_pulse(sof_pulse), .fetch_req(fetch_req), .frnum(frnum),
  .fetch_addr(fetch_addr), .base_q(base_q), .entry_valid(entry_valid),
  .entry_data(entry_data), .entry_term(entry_term)
);

// File: tb/tb_sof_frame_timer.sv
`timescale 1ns/1ps
module tb_sof_frame_timer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, bit_en, run, frnum_we, adj_we, base_we, entry_valid;
  logic [10:0] frnum_wdata;
  logic [7:0]  adj_wdata;
  logic [31:0] base_wdata, entry_data;
  logic [10:0] frnum;
  logic [7:0]  adj_q;
  logic [31:0] base_q, fetch_addr, entry_ptr;
  logic        sof_pulse, fetch_req, entry_term;

  sof_frame_timer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .run(run),
    .frnum_we(frnum_we), .frnum_wdata(frnum_wdata),
    .adj_we(adj_we), .adj_wdata(adj_wdata),
    .base_we(base_we), .base_wdata(base_wdata),
    .entry_valid(entry_valid), .entry_data(entry_data),
    .frnum(frnum), .adj_q(adj_q), .base_q(base_q), .fetch_addr(fetch_addr),
    .sof_pulse(sof_pulse), .fetch_req(fetch_req),
    .entry_ptr(entry_ptr), .entry_term(entry_term)
  );

  localparam logic [31:0] BASE = 32'h12345000;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int unsigned q_t[$];
  logic [10:0] q_f[$];
  int unsigned m_t;
  logic [10:0] m_f;

  function automatic logic [31:0] addr_of(input logic [10:0] f);
    return BASE | ({22'd0, f[9:0]} << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input int unsigned t, input logic [10:0] f);
    q_t.push_back(t);
    q_f.push_back(f);
  endtask

  task automatic wait_to(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && (sof_pulse || fetch_req)) begin
      chk(sof_pulse && fetch_req, "R2 strobes together", {30'd0, fetch_req, sof_pulse}, 32'd3);
      if (q_t.size() == 0) begin
        chk(1'b0, "R2/R4 unexpected start of frame", cyc, 32'd0);
      end else begin
        m_t = q_t.pop_front();
        m_f = q_f.pop_front();
        chk(cyc == m_t, "R2/R3/R4/R10 frame boundary cycle", cyc, m_t);
        chk(frnum == m_f, "R2/R6 frame number", {21'd0, frnum}, {21'd0, m_f});
        chk(fetch_addr == addr_of(m_f), "R8 fetch address", fetch_addr, addr_of(m_f));
      end
    end
  end

  always @(negedge clk) begin
    if (cyc >= 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned k, t1, t2, t3, t4;
    rst_n = 1'b0; bit_en = 1'b1; run = 1'b0;
    frnum_we = 1'b0; frnum_wdata = '0; adj_we = 1'b0; adj_wdata = '0;
    base_we = 1'b0; base_wdata = '0; entry_valid = 1'b0; entry_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frnum == 0, "R1 frame number", {21'd0, frnum}, 32'd0);
    chk(adj_q == 8'd64, "R1 adjust", {24'd0, adj_q}, 32'd64);
    chk(base_q == 0, "R1 base", base_q, 32'd0);
    chk(!sof_pulse && !fetch_req, "R1 strobes", {30'd0, fetch_req, sof_pulse}, 32'd0);

    base_we = 1'b1; base_wdata = 32'h12345ABC;
    @(negedge clk);
    base_we = 1'b0;
    chk(base_q == BASE, "R7 base page", base_q, BASE);
    chk(fetch_addr == addr_of(11'd0), "R8 idle address", fetch_addr, addr_of(11'd0));

    entry_valid = 1'b1; entry_data = 32'hDEADBEEF;
    @(negedge clk);
    entry_valid = 1'b0; entry_data = 32'h00001230;
    chk(entry_ptr == 32'hDEADBEE0, "R9 pointer", entry_ptr, 32'hDEADBEE0);
    chk(entry_term == 1'b1, "R9 terminate set", {31'd0, entry_term}, 32'd1);
    @(negedge clk);
    chk(entry_ptr == 32'hDEADBEE0 && entry_term, "R9 hold without valid", entry_ptr, 32'hDEADBEE0);
    entry_valid = 1'b1;
    @(negedge clk);
    entry_valid = 1'b0;
    chk(entry_ptr == 32'h00001230, "R9 second pointer", entry_ptr, 32'h00001230);
    chk(entry_term == 1'b0, "R9 terminate clear", {31'd0, entry_term}, 32'd0);

    k = cyc;
    run = 1'b1;
    t1 = k + 12000; t2 = t1 + 11936; t3 = t2 + 12191; t4 = t3 + 12300;
    push(t1, 11'd1); push(t2, 11'd2); push(t3, 11'd3); push(t4, 11'd4);
    wait_to(k + 100);
    adj_we = 1'b1; adj_wdata = 8'd0;
    @(negedge clk);
    adj_we = 1'b0;
    chk(adj_q == 8'd0, "R3 adjust readback", {24'd0, adj_q}, 32'd0);
    wait_to(t1 + 100);
    adj_we = 1'b1; adj_wdata = 8'd255;
    @(negedge clk);
    adj_we = 1'b0;
    wait_to(t1 + 200);
    frnum_we = 1'b1; frnum_wdata = 11'd500;
    @(negedge clk);
    frnum_we = 1'b0;
    chk(frnum == 11'd1, "R5 write ignored while running", {21'd0, frnum}, 32'd1);
    wait_to(t2 + 100);
    adj_we = 1'b1; adj_wdata = 8'd64;
    @(negedge clk);
    adj_we = 1'b0;
    wait_to(t3 + 5000);
    run = 1'b0;
    repeat (300) @(negedge clk);
    chk(frnum == 11'd3, "R4 frame number held", {21'd0, frnum}, 32'd3);
    run = 1'b1;
    wait_to(t4);

    run = 1'b0;
    frnum_we = 1'b1; frnum_wdata = 11'd1023;
    @(negedge clk);
    frnum_we = 1'b0;
    chk(frnum == 11'd1023, "R5 write accepted while halted", {21'd0, frnum}, 32'd1023);
    k = cyc;
    run = 1'b1;
    push(k + 12000, 11'd1024);
    push(k + 24000, 11'd1025);
    wait_to(k + 24000);

    run = 1'b0;
    frnum_we = 1'b1; frnum_wdata = 11'd2047;
    @(negedge clk);
    frnum_we = 1'b0;
    chk(frnum == 11'd2047, "R6 load top value", {21'd0, frnum}, 32'd2047);
    k = cyc;
    run = 1'b1;
    push(k + 12000, 11'd0);
    wait_to(k + 12000);

    k = cyc;
    push(k + 23999, 11'd1);
    while (cyc < k + 23999) begin
      bit_en = ((cyc - k) % 2 == 0);
      @(negedge clk);
    end
    bit_en = 1'b1;
    repeat (4) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(q_t.size() == 0, "R2/R10 all frames seen", q_t.size(), 32'd0);
    chk(frnum == 11'd1, "R10 final frame number", {21'd0, frnum}, 32'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule